// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block derives the timing of a serial audio link from one fast module clock. A coded master-clock ratio divides the module clock into master-clock ticks. A second coded ratio divides those ticks into bit-clock periods. A word length sets the number of bit-clock periods in each half of the frame clock. All outputs are synchronous to the module clock. They take the form of single-cycle strobes and level signals that downstream serialisers use as clock enables. No derived clock net is produced.

The two ratio codes map to fixed divide values:

- Master-clock code: 0 to 7 give 1, 2, 4, 6, 8, 12, 16 and 24.
- Bit-clock code: 0 to 5 give 2, 4, 6, 8, 12 and 16.

The codes use these values because the clock sources are 22.5792 MHz or 24.576 MHz. The oversample ratios of master clock to sample rate are 128, 192, 256, 384, 512 or 768. The bit-clock ratio equals the oversample ratio divided by twice the word length.

A master enable gates the whole chain. Codes outside the tables stop the clock they control and raise an error flag. A change to a valid code is taken up only at the end of the current divided period, so no shortened pulse appears. A word length of 0 counts as 2^WLEN_W bit periods.

Top module: `audio_clkdiv`

## Requirements
- R1: With `mclk_en` high and `mclk_code` in 0..7, `mclk_stb` is high for one module-clock cycle in every M cycles. M is 1, 2, 4, 6, 8, 12, 16 or 24 for codes 0..7. At ratio 1 it is high every cycle. The first strobe comes in the M-th cycle after enable.
- R2: `bclk_stb` is high once in every B master ticks, always in a cycle where `mclk_stb` is high. B is 2, 4, 6, 8, 12 or 16 for `bclk_code` 0..5.
- R3: `bclk_lvl` is high for the first B/2 master ticks of each bit period and low for the rest, giving a 50% duty cycle.
- R4: `lrck` starts low and toggles after every `word_len` bit periods. `frame_stb` is high on the last bit strobe of the high half. So it comes once per two words, in cycle 2·W·M·B−1 after enable.
- R5: While `mclk_en` is low, no strobe fires, `bclk_lvl` and `lrck` are low, and all counters are held at their start.
- R6: A `mclk_code` of 8..15 raises `cfg_err` at once and stops all strobes and levels.
- R7: A `bclk_code` of 6 or 7 raises `cfg_err` and stops `bclk_stb`, `bclk_lvl` and `lrck`, while the master strobes go on.
- R8: A change from one valid master code to another takes effect only after the strobe that ends the current master period.
- R9: After reset, with `mclk_en` low and valid codes, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en | input | 1 | Master-clock enable |
| mclk_code | input | 4 | Master-clock ratio code |
| bclk_code | input | 3 | Bit-clock ratio code |
| word_len | input | WLEN_W | Bit periods per frame-clock half |
| mclk_stb | output | 1 | Master-clock tick |
| bclk_stb | output | 1 | End of a bit period |
| bclk_lvl | output | 1 | Bit-clock level |
| lrck | output | 1 | Frame clock level |
| frame_stb | output | 1 | End of a two-word frame |
| cfg_err | output | 1 | Reserved ratio code present |

## Verification
The hardest case is a code change that lands in the middle of a master period. The change must not shorten that period, and the new ratio must apply from the next period onward. The stimulus enables an 8:1 ratio and switches the code to 2:1 three cycles after a strobe. It then checks the exact cycles in which strobes appear, on both sides of the switch. Each table vector runs for two full frames from a fresh enable. Strobe counts, high-level counts and the first `lrck` rise therefore pin down every ratio from its phase as well as its rate.

// File: rtl/audio_clkdiv.sv
module audio_clkdiv #(
  parameter int WLEN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_en,
  input  logic [3:0]        mclk_code,
  input  logic [2:0]        bclk_code,
  input  logic [WLEN_W-1:0] word_len,
  output logic              mclk_stb,
  output logic              bclk_stb,
  output logic              bclk_lvl,
  output logic              lrck,
  output logic              frame_stb,
  output logic              cfg_err
);
  localparam int RW = 5;

  function automatic logic [RW-1:0] m_ratio_of(input logic [3:0] c);
    case (c)
      4'd0:    return 5'd1;
      4'd1:    return 5'd2;
      4'd2:    return 5'd4;
      4'd3:    return 5'd6;
      4'd4:    return 5'd8;
      4'd5:    return 5'd12;
      4'd6:    return 5'd16;
      4'd7:    return 5'd24;
      default: return 5'd1;
    endcase
  endfunction

  function automatic logic [RW-1:0] b_ratio_of(input logic [2:0] c);
    case (c)
      3'd0:    return 5'd2;
      3'd1:    return 5'd4;
      3'd2:    return 5'd6;
      3'd3:    return 5'd8;
      3'd4:    return 5'd12;
      3'd5:    return 5'd16;
      default: return 5'd2;
    endcase
  endfunction

  logic [RW-1:0]     mcnt, m_ratio, bcnt, b_ratio;
  logic [WLEN_W-1:0] wcnt, w_len;
  logic              lr_q;

  wire m_bad  = mclk_code[3];
  wire b_bad  = (bclk_code > 3'd5);
  wire m_go   = mclk_en & ~m_bad;
  wire b_go   = m_go & ~b_bad;
  wire m_last = (mcnt == m_ratio - 5'd1);
  wire b_last = (bcnt == b_ratio - 5'd1);
  wire w_last = (wcnt == w_len - 1'b1);

  assign mclk_stb  = m_go & m_last;
  assign bclk_stb  = b_go & mclk_stb & b_last;
  assign bclk_lvl  = b_go & (bcnt < (b_ratio >> 1));
  assign lrck      = lr_q;
  assign frame_stb = bclk_stb & w_last & lr_q;
  assign cfg_err   = m_bad | b_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt    <= '0;
      m_ratio <= 5'd1;
    end else if (!m_go) begin
      mcnt    <= '0;
      m_ratio <= m_ratio_of(mclk_code);
    end else if (m_last) begin
      mcnt    <= '0;
      m_ratio <= m_ratio_of(mclk_code);
    end else begin
      mcnt    <= mcnt + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt    <= '0;
      b_ratio <= 5'd2;
    end else if (!b_go) begin
      bcnt    <= '0;
      b_ratio <= b_ratio_of(bclk_code);
    end else if (mclk_stb) begin
      if (b_last) begin
        bcnt    <= '0;
        b_ratio <= b_ratio_of(bclk_code);
      end else begin
        bcnt    <= bcnt + 5'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      w_len <= '0;
      lr_q <= 1'b0;
    end else if (!b_go) begin
      wcnt  <= '0;
      w_len <= word_len;
      lr_q  <= 1'b0;
    end else if (bclk_stb) begin
      if (w_last) begin
        wcnt  <= '0;
        w_len <= word_len;
        lr_q  <= ~lr_q;
      end else begin
        wcnt  <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_clkdiv_chk.sv
module audio_clkdiv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mclk_en,
  input logic [3:0] mclk_code,
  input logic [2:0] bclk_code,
  input logic       mclk_stb,
  input logic       bclk_stb,
  input logic       bclk_lvl,
  input logic       lrck,
  input logic       frame_stb
);
  assert_bclk_on_mclk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_stb |-> mclk_stb);

  assert_idle_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |-> (!mclk_stb && !bclk_stb && !bclk_lvl));

  assert_idle_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |=> !lrck);

  assert_mclk_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_code[3] |-> (!mclk_stb && !bclk_lvl));

  assert_bclk_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_code > 3'd5) |-> (!bclk_stb && !bclk_lvl && !frame_stb));

  assert_frame_on_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (bclk_stb && lrck));

  assert_lrck_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lrck) && $past(mclk_en) && $past(!mclk_code[3]) && $past(bclk_code < 3'd6))
      |-> $past(bclk_stb));
endmodule

bind audio_clkdiv audio_clkdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .mclk_code(mclk_code),
  .bclk_code(bclk_code), .mclk_stb(mclk_stb), .bclk_stb(bclk_stb),
  .bclk_lvl(bclk_lvl), .lrck(lrck), .frame_stb(frame_stb)
);

// File: tb/tb_audio_clkdiv.sv
module tb_audio_clkdiv;
  localparam int WLEN_W = 6;

  logic clk = 1'b0, rst_n = 1'b0, mclk_en = 1'b0;
  logic [3:0] mclk_code = '0;
  logic [2:0] bclk_code = '0;
  logic [WLEN_W-1:0] word_len = 6'd2;
  logic mclk_stb, bclk_stb, bclk_lvl, lrck, frame_stb, cfg_err;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_clkdiv #(.WLEN_W(WLEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .mclk_code(mclk_code),
    .bclk_code(bclk_code), .word_len(word_len), .mclk_stb(mclk_stb),
    .bclk_stb(bclk_stb), .bclk_lvl(bclk_lvl), .lrck(lrck),
    .frame_stb(frame_stb), .cfg_err(cfg_err)
  );

  // {mclk code, bclk code, word length, M, B}
  localparam logic [22:0] VEC [0:7] = '{
    {4'd0, 3'd0, 6'd2, 5'd1,  5'd2},
    {4'd1, 3'd1, 6'd2, 5'd2,  5'd4},
    {4'd2, 3'd2, 6'd2, 5'd4,  5'd6},
    {4'd3, 3'd3, 6'd2, 5'd6,  5'd8},
    {4'd4, 3'd4, 6'd1, 5'd8,  5'd12},
    {4'd5, 3'd5, 6'd1, 5'd12, 5'd16},
    {4'd6, 3'd0, 6'd3, 5'd16, 5'd2},
    {4'd7, 3'd1, 6'd2, 5'd24, 5'd4}
  };

  int nm, nb, nhi, nfr, first_rise, first_frame, nerr, nlr;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic window(input int n);
    nm = 0; nb = 0; nhi = 0; nfr = 0; nerr = 0; nlr = 0;
    first_rise = -1; first_frame = -1;
    for (int i = 0; i < n; i++) begin
      #2;
      nm += int'(mclk_stb);
      nb += int'(bclk_stb);
      nhi += int'(bclk_lvl);
      nerr += int'(cfg_err);
      nlr += int'(lrck);
      if (frame_stb) begin
        nfr++;
        if (first_frame < 0) first_frame = i;
      end
      if (lrck && first_rise < 0) first_rise = i;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [3:0] mc, input logic [2:0] bc, input logic [5:0] wl);
    @(negedge clk);
    mclk_en = 1'b0; mclk_code = mc; bclk_code = bc; word_len = wl;
    repeat (2) @(negedge clk);
    mclk_en = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: outputs during and after reset
    #5;
    check("R9 reset outputs", int'({mclk_stb, bclk_stb, bclk_lvl, lrck, frame_stb, cfg_err}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R9 after reset outputs", int'({mclk_stb, bclk_stb, bclk_lvl, lrck, frame_stb, cfg_err}), 0);

    // Table of ratio vectors: R1..R4
    for (int v = 0; v < 8; v++) begin
      automatic int m = int'(VEC[v][9:5]);
      automatic int b = int'(VEC[v][4:0]);
      automatic int w = int'(VEC[v][15:10]);
      automatic int f = 2 * w * m * b;
      setup(VEC[v][22:19], VEC[v][18:16], VEC[v][15:10]);
      window(2 * f);
      check($sformatf("R1 mclk count v%0d", v), nm, 2 * f / m);
      check($sformatf("R2 bclk count v%0d", v), nb, 2 * f / (m * b));
      check($sformatf("R3 bclk high v%0d", v), nhi, f);
      check($sformatf("R4 lrck first rise v%0d", v), first_rise, f / 2);
      check($sformatf("R4 frame count v%0d", v), nfr, 2);
      check($sformatf("R4 frame first v%0d", v), first_frame, f - 1);
    end

    // R5: disabled chain stays quiet
    @(negedge clk);
    mclk_en = 1'b0; mclk_code = 4'd1; bclk_code = 3'd0; word_len = 6'd1;
    @(negedge clk);
    window(20);
    check("R5 disabled strobes", nm + nb + nfr, 0);
    check("R5 disabled levels", nhi + nlr, 0);

    // R6: reserved master code
    @(negedge clk);
    mclk_en = 1'b1; mclk_code = 4'd9;
    window(20);
    check("R6 reserved mclk strobes", nm + nb + nhi + nlr, 0);
    check("R6 reserved mclk err", nerr, 20);
    mclk_code = 4'd15;
    window(10);
    check("R6 code 15 err", nerr, 10);

    // R7: reserved bit-clock codes, master keeps running
    setup(4'd1, 3'd6, 6'd1);
    window(20);
    check("R7 code 6 mclk runs", nm, 10);
    check("R7 code 6 bclk stopped", nb + nhi + nlr, 0);
    check("R7 code 6 err", nerr, 20);
    setup(4'd1, 3'd7, 6'd1);
    window(20);
    check("R7 code 7 bclk stopped", nb + nhi + nlr, 0);
    check("R7 code 7 err", nerr, 20);

    // R8: code change mid period waits for the boundary
    setup(4'd4, 3'd0, 6'd4);
    begin
      automatic int bad = 0;
      for (int i = 0; i < 30; i++) begin
        automatic bit exp;
        #2;
        exp = (i == 7) || (i >= 15 && ((i - 15) % 2 == 0));
        if (mclk_stb != exp) bad++;
        @(negedge clk);
        if (i == 10) mclk_code = 4'd1;
      end
      check("R8 ratio change at boundary", bad, 0);
    end
    check("R8 err stays low", int'(cfg_err), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule